// File: doc/BRIEF.md
# Two-Step Flash Conversion Sequencer

This block is the digital control and decode core of a two-step ("half-flash") analog-to-digital converter. A single bank of sixteen comparators is shared between two conversion steps. A coarse estimator gives a rough position of the input in sixteenths of full scale. From that position the block places a sixteen-tap window on the coarse ladder, which has 64 taps. The window reaches one sixteenth below the estimate and two sixteenths above it, so an estimator that is wrong by one sixteenth still gives the correct upper six bits. The same comparator bank is then moved onto the fine ladder, which has sixteen steps of one code each and sits above the chosen coarse tap. The fine step gives the lower four bits, and the block latches the full 10-bit word.

The comparators and ladders are outside the block. The block tells them where to look through two outputs: `win_fine_o` selects the ladder and `win_tap_o` gives the tap index. It reads their decisions as thermometer vectors. Thermometers are decoded by counting ones, so a bubble in the pattern does not upset the result. The step lengths come from an internal timer and not from an outside conversion clock.

The sequence is run by a state machine with five states:
- ST_IDLE: waits for a start request.
- ST_ESTIM: captures the estimator thermometer and places the coarse window.
- ST_COARSE: holds the bank on the coarse window for COARSE_CYC cycles, then takes the upper bits.
- ST_FINE: holds the bank on the fine ladder for FINE_CYC cycles, then latches the word.
- ST_DONE: gives the completion pulse.

The transitions are:
- IDLE to ESTIM on `start_i`.
- ESTIM to COARSE always.
- COARSE to FINE when the timer expires.
- FINE to DONE when the timer expires.
- DONE to IDLE always.

Top module: `hfs_sequencer`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `win_fine_o`, `win_tap_o` and `code_o` are all zero.
- R2: `start_i` is acted on only in ST_IDLE. A start request while a conversion is running changes neither the timing nor the result of that conversion.
- R3: The estimator vector has 15 bits. Its count of ones, e (0..15), sets the coarse base tap to 4*min(max(e-1,0),12). Throughout ST_COARSE, `win_fine_o`=0 and `win_tap_o` equals that base. The base is therefore a multiple of 4 and at most 48.
- R4: The upper six bits, `code_o[9:4]`, equal base + n - 1, where n is the count of ones in the 16-bit bank vector at the end of the coarse step. The value saturates at 0 when the sum is 0 and at 63 above that.
- R5: Throughout ST_FINE, `win_fine_o`=1 and `win_tap_o` equals the upper six bits. The lower four bits, `code_o[3:0]`, equal n-1 for the fine bank count n (0..16), with 0 when n is 0.
- R6: With ideal comparators, an estimator count within one sixteenth (±1) of the true value gives a result equal to the ideal 10-bit code.
- R7: Thermometer vectors are decoded by their count of ones only. A bubble that keeps the count gives the same result.
- R8: `done_o` is a one-cycle pulse in the cycle after the result is latched. It is raised after the (COARSE_CYC+FINE_CYC+2)-th rising edge, counting the edge that samples `start_i` as the first. `code_o` keeps its value until the next latch.
- R9: The bank stays on the coarse ladder for exactly COARSE_CYC cycles and then on the fine ladder for exactly FINE_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion request |
| est_therm_i | input | 15 | Estimator comparator thermometer |
| bank_therm_i | input | 16 | Shared comparator bank thermometer |
| win_fine_o | output | 1 | 0 = bank on coarse ladder, 1 = bank on fine ladder |
| win_tap_o | output | 6 | Coarse base tap, or the chosen coarse tap during the fine step |
| busy_o | output | 1 | High in ST_ESTIM, ST_COARSE and ST_FINE |
| done_o | output | 1 | Completion pulse |
| code_o | output | 10 | Latched conversion result |

## Verification
Every conversion is timed from the rising edge that samples `start_i`. The coarse window must be seen on `win_tap_o` after edge 2 and must stay there until edge COARSE_CYC+1. After that edge the fine tap must appear, and it must hold through edge COARSE_CYC+FINE_CYC+1. The result and `done_o` are due after edge COARSE_CYC+FINE_CYC+2, and `done_o` must be low again one edge later. The bench drives inputs at falling edges and samples every output at the falling edge that follows each of these counted rising edges. It models the comparators directly from an integer input code and the window outputs, so each value it expects is computed at the point where it is due.

// File: rtl/hfs_pkg.sv
package hfs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ESTIM,
        ST_COARSE,
        ST_FINE,
        ST_DONE
    } hfs_state_e;
endpackage

// File: rtl/hfs_ones_count.sv
// Counts ones in a thermometer vector; tolerant of bubbles (R7).
module hfs_ones_count #(
    parameter int W = 16,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  therm,
    output logic [CW-1:0] ones
);
    always_comb begin
        ones = '0;
        for (int i = 0; i < W; i++) begin
            ones = ones + CW'(therm[i]);
        end
    end
endmodule

// File: rtl/hfs_window.sv
// Places the coarse window one section below the estimate, clamped to the ladder.
module hfs_window #(
    parameter int EST_BITS = 4,
    parameter int MSB_BITS = 6,
    parameter int BANK     = 16
) (
    input  logic [EST_BITS-1:0] est_idx,
    output logic [MSB_BITS-1:0] base_tap
);
    localparam int TPS_SH   = MSB_BITS - EST_BITS;
    localparam int SECTIONS = 2 ** EST_BITS;
    localparam int WIN_SECS = BANK >> TPS_SH;
    localparam int MAX_SEC  = SECTIONS - WIN_SECS;

    logic [EST_BITS-1:0] sec;

    always_comb begin
        sec = (est_idx == '0) ? '0 : est_idx - 1'b1;
        if (int'(sec) > MAX_SEC) begin
            sec = EST_BITS'(MAX_SEC);
        end
        base_tap = MSB_BITS'(sec) << TPS_SH;
    end
endmodule

// File: rtl/hfs_offset_sat.sv
// code = base + ones - 1, saturating at zero and at the top of the output range.
module hfs_offset_sat #(
    parameter int OW = 6,
    parameter int CW = 5
) (
    input  logic [OW-1:0] base,
    input  logic [CW-1:0] ones,
    output logic [OW-1:0] code
);
    localparam int SW = ((OW > CW) ? OW : CW) + 1;
    localparam logic [SW-1:0] TOP = SW'((1 << OW) - 1);

    logic [SW-1:0] sum;

    always_comb begin
        sum = SW'(base) + SW'(ones);
        if (sum == '0) begin
            code = '0;
        end else if (sum - 1'b1 > TOP) begin
            code = '1;
        end else begin
            code = OW'(sum - 1'b1);
        end
    end
endmodule

// File: rtl/hfs_sequencer.sv
module hfs_sequencer
    import hfs_pkg::*;
#(
    parameter int MSB_BITS   = 6,
    parameter int LSB_BITS   = 4,
    parameter int EST_BITS   = 4,
    parameter int COARSE_CYC = 4,
    parameter int FINE_CYC   = 4,
    localparam int BANK      = 2 ** LSB_BITS,
    localparam int EST_W     = 2 ** EST_BITS - 1,
    localparam int RES       = MSB_BITS + LSB_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [EST_W-1:0]    est_therm_i,
    input  logic [BANK-1:0]     bank_therm_i,
    output logic                win_fine_o,
    output logic [MSB_BITS-1:0] win_tap_o,
    output logic                busy_o,
    output logic                done_o,
    output logic [RES-1:0]      code_o
);
    localparam int BCW     = $clog2(BANK + 1);
    localparam int ECW     = $clog2(EST_W + 1);
    localparam int TMAX    = (COARSE_CYC > FINE_CYC) ? COARSE_CYC : FINE_CYC;
    localparam int TW      = $clog2(TMAX + 1);
    localparam int TPS     = 2 ** (MSB_BITS - EST_BITS);
    localparam int MAX_BASE = (2 ** MSB_BITS) - BANK;

    hfs_state_e          state_q, state_d;
    logic [TW-1:0]       tmr_q;
    logic [MSB_BITS-1:0] base_q, msb_q;
    logic [RES-1:0]      code_q;
    logic                tmr_zero;

    logic [ECW-1:0]      est_ones;
    logic [BCW-1:0]      bank_ones;
    logic [MSB_BITS-1:0] base_w, msb_w;
    logic [LSB_BITS-1:0] lsb_w;

    hfs_ones_count #(.W(EST_W)) u_est_cnt  (.therm(est_therm_i),  .ones(est_ones));
    hfs_ones_count #(.W(BANK))  u_bank_cnt (.therm(bank_therm_i), .ones(bank_ones));

    hfs_window #(.EST_BITS(EST_BITS), .MSB_BITS(MSB_BITS), .BANK(BANK)) u_win (
        .est_idx  (EST_BITS'(est_ones)),
        .base_tap (base_w)
    );

    hfs_offset_sat #(.OW(MSB_BITS), .CW(BCW)) u_msb (
        .base (base_q),
        .ones (bank_ones),
        .code (msb_w)
    );

    hfs_offset_sat #(.OW(LSB_BITS), .CW(BCW)) u_lsb (
        .base ('0),
        .ones (bank_ones),
        .code (lsb_w)
    );

    assign tmr_zero = (tmr_q == '0);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i)  state_d = ST_ESTIM;
            ST_ESTIM:                state_d = ST_COARSE;
            ST_COARSE: if (tmr_zero) state_d = ST_FINE;
            ST_FINE:   if (tmr_zero) state_d = ST_DONE;
            ST_DONE:                 state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Step timer and captured values
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q  <= '0;
            base_q <= '0;
            msb_q  <= '0;
            code_q <= '0;
        end else begin
            unique case (state_q)
                ST_ESTIM: begin
                    base_q <= base_w;
                    tmr_q  <= TW'(COARSE_CYC - 1);
                end
                ST_COARSE: begin
                    if (tmr_zero) begin
                        msb_q <= msb_w;
                        tmr_q <= TW'(FINE_CYC - 1);
                    end else begin
                        tmr_q <= tmr_q - 1'b1;
                    end
                end
                ST_FINE: begin
                    if (tmr_zero) code_q <= {msb_q, lsb_w};
                    else          tmr_q  <= tmr_q - 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        win_fine_o = 1'b0;
        win_tap_o  = base_q;
        busy_o     = 1'b0;
        done_o     = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_ESTIM:  busy_o = 1'b1;
            ST_COARSE: busy_o = 1'b1;
            ST_FINE: begin
                busy_o     = 1'b1;
                win_fine_o = 1'b1;
                win_tap_o  = msb_q;
            end
            ST_DONE:   done_o = 1'b1;
            default:   ;
        endcase
    end

    assign code_o = code_q;

    assert_start_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> (busy_o || done_o));

    assert_window_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COARSE) |-> (int'(win_tap_o) <= MAX_BASE && (int'(win_tap_o) % TPS) == 0));

    assert_fine_tap_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FINE && !tmr_zero) |=> $stable(win_tap_o));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_code_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_FINE) |=> $stable(code_o));

    assert_coarse_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COARSE && !tmr_zero) |=> (state_q == ST_COARSE));
endmodule

// File: tb/tb_hfs_sequencer.sv
module tb_hfs_sequencer;
    localparam int CLK_P = 10;
    localparam int CC    = 4;
    localparam int FC    = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [14:0] est_therm;
    logic [15:0] bank_therm;
    logic        win_fine, busy, done;
    logic [5:0]  win_tap;
    logic [9:0]  code;

    int vin = 0;
    int est_n = 0;
    bit bub = 1'b0;
    int n_chk = 0;
    int n_bad = 0;

    hfs_sequencer #(.COARSE_CYC(CC), .FINE_CYC(FC)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .est_therm_i(est_therm), .bank_therm_i(bank_therm),
        .win_fine_o(win_fine), .win_tap_o(win_tap),
        .busy_o(busy), .done_o(done), .code_o(code)
    );

    always #(CLK_P / 2) clk = ~clk;

    function automatic logic [15:0] mk_therm(int n, int w, bit b);
        logic [15:0] t = '0;
        for (int i = 0; i < n; i++) t[i] = 1'b1;
        if (b && n >= 1 && n < w) begin
            t[n] = 1'b1;
            t[n-1] = 1'b0;
        end
        return t;
    endfunction

    // Ideal comparator models driven from the input code and window outputs
    always @* begin
        int cnt;
        cnt = 0;
        for (int k = 0; k < 16; k++) begin
            if (!win_fine) begin
                if (vin >= (int'(win_tap) + k) * 16) cnt++;
            end else begin
                if (vin >= int'(win_tap) * 16 + k) cnt++;
            end
        end
        bank_therm = mk_therm(cnt, 16, bub);
        est_therm  = mk_therm(est_n, 15, bub)[14:0];
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d (vin=%0d est=%0d)", tag, act, exp, vin, est_n);
        end
    endtask

    task automatic convert(int v, int e, bit b, bit mid_start, bit ideal);
        int base, ones, msb, fones, lsb, expc;
        vin = v; est_n = e; bub = b;
        base = e - 1;
        if (base < 0) base = 0;
        if (base > 12) base = 12;
        base = base * 4;
        if (v < base * 16) ones = 0;
        else begin
            ones = (v >> 4) - base + 1;
            if (ones > 16) ones = 16;
        end
        msb = base + ones - 1;
        if (msb < 0) msb = 0;
        if (msb > 63) msb = 63;
        if (v < msb * 16) fones = 0;
        else begin
            fones = v - msb * 16 + 1;
            if (fones > 16) fones = 16;
        end
        lsb = (fones == 0) ? 0 : fones - 1;
        expc = msb * 16 + lsb;

        @(negedge clk); start = 1'b1;
        @(posedge clk); @(negedge clk); start = 1'b0;
        for (int k = 2; k <= CC + FC + 3; k++) begin
            @(posedge clk); @(negedge clk);
            start = 1'b0;
            if (k <= CC + 1) begin
                chk(!win_fine, "R9 coarse phase", win_fine, 0);
                chk(int'(win_tap) == base, "R3 coarse base", win_tap, base);
                chk(busy, "R2 busy", busy, 1);
            end else if (k <= CC + FC + 1) begin
                chk(win_fine, "R9 fine phase", win_fine, 1);
                chk(int'(win_tap) == msb, "R5 fine tap", win_tap, msb);
            end
            if (k == CC + FC + 2) begin
                chk(done, "R8 done due", done, 1);
                chk(int'(code[9:4]) == msb, "R4 upper bits", code[9:4], msb);
                chk(int'(code[3:0]) == lsb, "R5 lower bits", code[3:0], lsb);
                if (ideal) chk(int'(code) == v, b ? "R7 bubble result" : "R6 ideal result", code, v);
            end else begin
                chk(!done, "R8 done pulse", done, 0);
            end
            if (k == CC + FC + 3) chk(int'(code) == expc, "R8 result held", code, expc);
            if (mid_start && k == 3) start = 1'b1;
        end
    endtask

    initial begin
        #(CLK_P * 190000);
        n_bad++;
        $display("FAIL watchdog: got %0d expected %0d", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!busy && !done && !win_fine, "R1 reset flags", {busy, done, win_fine}, 0);
        chk(code == '0 && win_tap == '0, "R1 reset values", code, 0);
        rst_n = 1'b1;

        // Full sweep, estimator off by -1, 0, +1 sixteenth
        for (int v = 0; v < 1024; v++) begin
            for (int d = -1; d <= 1; d++) begin
                int e;
                e = (v >> 6) + d;
                if (e < 0) e = 0;
                if (e > 15) e = 15;
                convert(v, e, (v % 3) == 0, (v % 7) == 0, 1'b1);
            end
        end

        // Estimator far off: saturation corners (R4)
        convert(0, 15, 1'b0, 1'b0, 1'b0);
        chk(int'(code) == 752, "R4 low saturation", code, 752);
        convert(1023, 0, 1'b0, 1'b0, 1'b0);
        chk(int'(code) == 255, "R4 high saturation", code, 255);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule